// File: doc/BRIEF.md
# Flow Report Packetizer

This block queues per-flow statistics records and sends each one out as a UDP datagram on a 32-bit streaming output. A record holds a flow identifier, the timestamps at which the flow began and ended, and four 16-bit match counters. An upstream producer writes a record into an internal synchronous queue with a one-cycle push strobe. Whenever the queue is non-empty and no datagram is being sent, the block starts a new datagram. It keeps sending datagrams one after another until the queue is empty.

A datagram has nine beats. The first beat carries the source port in the upper half and the destination port in the lower half. The second beat carries the UDP length in the upper half and a zero checksum in the lower half. Seven payload beats follow. The output uses a valid/ready handshake, with start-of-packet and end-of-packet markers. A sink that lowers ready freezes the stream on the current beat.

Top module: `udp_report_packetizer`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, fifo_full and overflow are all low.
- R2: The first beat of every datagram is {SRC_PORT[15:0], DST_PORT[15:0]}, and it is the only beat with out_sop high.
- R3: The second beat is {16'd36, 16'h0000}: the length is the 8-byte header plus the 28-byte payload, and the checksum is zero.
- R4: Beats three, four and five carry the flow identifier, the start timestamp and the end timestamp of the record, in that order.
- R5: Beats six to nine carry counters 0 to 3 in that order, each zero-extended to 32 bits. Counter k is push_counts[16k+15:16k]. The ninth beat is the only beat with out_eop high.
- R6: out_valid stays low while the queue is empty. Each pushed record produces exactly one datagram, and records leave in the order they were pushed.
- R7: While out_valid is high and out_ready is low, out_valid, out_data, out_sop and out_eop keep their values into the next cycle.
- R8: The queue holds DEPTH (16) records, and fifo_full is high when it holds DEPTH. A push while the queue is full is dropped, even if a pop happens in the same cycle. Such a push sets overflow, which stays high until reset.
- R9: Every datagram is exactly nine accepted beats, and out_sop and out_eop are never high on the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Write one record into the queue this cycle |
| push_flow_id | input | 32 | Flow identifier of the record |
| push_start_ts | input | 32 | Flow start timestamp |
| push_end_ts | input | 32 | Flow end timestamp |
| push_counts | input | 64 | Four 16-bit counters; counter k at bits 16k+15:16k |
| fifo_full | output | 1 | Queue holds DEPTH records |
| overflow | output | 1 | Sticky: a push was dropped because the queue was full |
| out_ready | input | 1 | Sink accepts the current beat |
| out_valid | output | 1 | A beat is presented on out_data |
| out_data | output | 32 | Beat contents |
| out_sop | output | 1 | First beat of a datagram |
| out_eop | output | 1 | Last beat of a datagram |

## Verification
The hold-stable property assumes that the sink may drop ready at any beat. The property is only meaningful because the design never withdraws a beat on its own. The stimulus therefore uses several ready patterns: always high, alternating, two-of-three, and held low. The pop check assumes that only the serializer removes queue entries. The full-queue property assumes that the producer may push in any cycle. The overflow part of the stimulus pushes deliberately while the queue is full and the sink is stalled, so that no pop can hide the drop.

// File: rtl/report_pkg.sv
package report_pkg;

    localparam int FID_W     = 32;
    localparam int TS_W      = 32;
    localparam int CNT_W     = 16;
    localparam int NUM_CNT   = 4;
    localparam int WORD_W    = 32;
    localparam int HDR_BEATS = 2;
    localparam int PAY_WORDS = 3 + NUM_CNT;
    localparam int NUM_BEATS = HDR_BEATS + PAY_WORDS;
    localparam int BEAT_W    = $clog2(NUM_BEATS);
    localparam int UDP_HDR_BYTES = 8;
    localparam int UDP_LEN   = UDP_HDR_BYTES + PAY_WORDS * (WORD_W / 8);

    typedef struct packed {
        logic [FID_W-1:0]                flow_id;
        logic [TS_W-1:0]                 t_start;
        logic [TS_W-1:0]                 t_end;
        logic [NUM_CNT-1:0][CNT_W-1:0]   counts;
    } flow_rec_t;

    typedef enum logic [0:0] {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_t;

    function automatic logic [WORD_W-1:0] payload_word(input flow_rec_t r, input int idx);
        logic [WORD_W-1:0] w;
        w = '0;
        if (idx == 0) begin
            w = WORD_W'(r.flow_id);
        end else if (idx == 1) begin
            w = WORD_W'(r.t_start);
        end else if (idx == 2) begin
            w = WORD_W'(r.t_end);
        end else begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (idx == 3 + k) begin
                    w = {{(WORD_W-CNT_W){1'b0}}, r.counts[k]};
                end
            end
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] port_word(input logic [15:0] src, input logic [15:0] dst);
        return {src, dst};
    endfunction

    function automatic logic [WORD_W-1:0] len_word();
        return {16'(UDP_LEN), 16'h0000};
    endfunction

endpackage

// File: rtl/report_fifo.sv
module report_fifo
    import report_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  flow_rec_t wr_rec,
    input  logic      rd_en,
    output flow_rec_t rd_rec,
    output logic      empty,
    output logic      full,
    output logic      overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    flow_rec_t          mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [OCC_W-1:0]   occ;
    logic               wr_ok;
    logic               rd_ok;

    assign full   = (occ == FULL_OCC);
    assign empty  = (occ == '0);
    assign wr_ok  = wr_en && !full;
    assign rd_ok  = rd_en && !empty;
    assign rd_rec = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            if (wr_ok && !rd_ok) begin
                occ <= occ + 1'b1;
            end else if (rd_ok && !wr_ok) begin
                occ <= occ - 1'b1;
            end
            if (wr_en && full) begin
                overflow <= 1'b1;
            end
        end
    end

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R8

    AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && overflow)); // R8

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_OCC); // R8

endmodule

// File: rtl/report_beat_mux.sv
module report_beat_mux
    import report_pkg::*;
#(
    parameter logic [15:0] SRC_PORT = 16'h1F90,
    parameter logic [15:0] DST_PORT = 16'h2329
) (
    input  logic [BEAT_W-1:0] beat,
    input  flow_rec_t         rec,
    output logic [WORD_W-1:0] data,
    output logic              sop,
    output logic              eop
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_BEATS - 1);

    always_comb begin
        if (beat == '0) begin
            data = port_word(SRC_PORT, DST_PORT);
        end else if (beat == BEAT_W'(1)) begin
            data = len_word();
        end else begin
            data = payload_word(rec, int'(beat) - HDR_BEATS);
        end
    end

    assign sop = (beat == '0);
    assign eop = (beat == LAST_BEAT);

endmodule

// File: rtl/report_serializer.sv
module report_serializer
    import report_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flow_rec_t         head,
    input  logic              fifo_empty,
    output logic              pop,
    output flow_rec_t         rec,
    output logic [BEAT_W-1:0] beat,
    input  logic              out_ready,
    output logic              out_valid
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_BEATS - 1);
    localparam logic [BEAT_W-1:0] POP_BEAT  = BEAT_W'(HDR_BEATS);

    ser_state_t        state;
    logic [BEAT_W-1:0] beat_q;
    flow_rec_t         rec_q;
    logic              take;

    assign out_valid = (state == SER_SEND);
    assign take      = out_valid && out_ready;
    assign pop       = take && (beat_q == POP_BEAT);
    assign beat      = beat_q;
    assign rec       = rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SER_IDLE;
            beat_q <= '0;
            rec_q  <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (!fifo_empty) begin
                        state  <= SER_SEND;
                        beat_q <= '0;
                        rec_q  <= head;
                    end
                end
                SER_SEND: begin
                    if (take) begin
                        if (beat_q == LAST_BEAT) begin
                            state  <= SER_IDLE;
                            beat_q <= '0;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty); // R6

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (take && beat_q == LAST_BEAT) |=> !out_valid); // R9

    AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        beat_q <= LAST_BEAT); // R9

endmodule

// File: rtl/udp_report_packetizer.sv
module udp_report_packetizer
    import report_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter logic [15:0] SRC_PORT = 16'h1F90,
    parameter logic [15:0] DST_PORT = 16'h2329
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_valid,
    input  logic [FID_W-1:0]         push_flow_id,
    input  logic [TS_W-1:0]          push_start_ts,
    input  logic [TS_W-1:0]          push_end_ts,
    input  logic [NUM_CNT*CNT_W-1:0] push_counts,
    output logic                     fifo_full,
    output logic                     overflow,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_sop,
    output logic                     out_eop
);
    flow_rec_t         wr_rec;
    flow_rec_t         head;
    flow_rec_t         cur_rec;
    logic              fifo_empty;
    logic              pop;
    logic [BEAT_W-1:0] beat;

    assign wr_rec.flow_id = push_flow_id;
    assign wr_rec.t_start = push_start_ts;
    assign wr_rec.t_end   = push_end_ts;
    assign wr_rec.counts  = push_counts;

    report_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (push_valid),
        .wr_rec   (wr_rec),
        .rd_en    (pop),
        .rd_rec   (head),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .overflow (overflow)
    );

    report_serializer i_ser (
        .clk        (clk),
        .rst        (rst),
        .head       (head),
        .fifo_empty (fifo_empty),
        .pop        (pop),
        .rec        (cur_rec),
        .beat       (beat),
        .out_ready  (out_ready),
        .out_valid  (out_valid)
    );

    report_beat_mux #(.SRC_PORT(SRC_PORT), .DST_PORT(DST_PORT)) i_mux (
        .beat (beat),
        .rec  (cur_rec),
        .data (out_data),
        .sop  (out_sop),
        .eop  (out_eop)
    );

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R7

    AST_SOP_EOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop)); // R9

    AST_SOP_IS_PORTS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (out_data == {SRC_PORT, DST_PORT})); // R2

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(fifo_empty) && fifo_empty && !$past(out_valid)) |-> !out_valid); // R6

endmodule

// File: tb/test_udp_report_packetizer.sv
module test_udp_report_packetizer;

    localparam logic [15:0] SRC = 16'h1F90;
    localparam logic [15:0] DST = 16'h2329;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [31:0] push_flow_id = '0;
    logic [31:0] push_start_ts = '0;
    logic [31:0] push_end_ts = '0;
    logic [63:0] push_counts = '0;
    logic        fifo_full;
    logic        overflow;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int checks = 0;
    int errors = 0;
    int tcyc = 0;
    int mode = 0;
    int exp_id [256];
    int exp_wr = 0;
    int pkt_seen = 0;
    int bidx = 0;
    bit running = 0;
    bit stall_prev = 0;
    logic [31:0] prev_data;
    logic prev_sop, prev_eop;

    always #2.5 clk = ~clk;

    udp_report_packetizer #(.DEPTH(DEPTH), .SRC_PORT(SRC), .DST_PORT(DST)) i_udp_report_packetizer (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_flow_id(push_flow_id),
        .push_start_ts(push_start_ts), .push_end_ts(push_end_ts), .push_counts(push_counts),
        .fifo_full(fifo_full), .overflow(overflow), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    function automatic logic [31:0] g_fid(input int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
    endfunction
    function automatic logic [31:0] g_ts0(input int i);
        return 32'(i) * 32'd1000 + 32'd7;
    endfunction
    function automatic logic [31:0] g_ts1(input int i);
        return g_ts0(i) + 32'd12345;
    endfunction
    function automatic logic [15:0] g_cnt(input int i, input int k);
        if (k == 3) return 16'hFFFF - 16'(i);
        return 16'(i) * 16'h0111 + 16'(k);
    endfunction
    function automatic logic [31:0] exp_beat(input int i, input int b);
        case (b)
            0: return {SRC, DST};
            1: return {16'd36, 16'h0000};
            2: return g_fid(i);
            3: return g_ts0(i);
            4: return g_ts1(i);
            default: return {16'h0000, g_cnt(i, b - 5)};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_rec(input int i, input bit logged);
        push_valid    = 1'b1;
        push_flow_id  = g_fid(i);
        push_start_ts = g_ts0(i);
        push_end_ts   = g_ts1(i);
        for (int k = 0; k < 4; k++) push_counts[16*k +: 16] = g_cnt(i, k);
        if (logged) begin
            exp_id[exp_wr] = i;
            exp_wr++;
        end
        @(posedge clk); #1;
        push_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        tcyc++;
        #1;
        case (mode)
            0: out_ready = 1'b1;
            1: out_ready = tcyc[0];
            2: out_ready = (tcyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        if (tcyc > 100000) begin
            errors++;
            $display("FAIL R6 watchdog: packets actual %0d expected %0d", pkt_seen, exp_wr);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (running && !rst) begin
            if (stall_prev) begin
                check("R7", {31'b0, out_valid}, 32'd1, "valid held during stall");
                check("R7", out_data, prev_data, "data held during stall");
                check("R7", {30'b0, out_sop, out_eop}, {30'b0, prev_sop, prev_eop}, "markers held during stall");
            end
            stall_prev = out_valid && !out_ready;
            prev_data = out_data;
            prev_sop = out_sop;
            prev_eop = out_eop;
            if (out_valid && out_ready) begin
                if (pkt_seen >= exp_wr) begin
                    errors++;
                    checks++;
                    $display("FAIL R6 unexpected beat: actual %h expected none", out_data);
                end else begin
                    int id;
                    id = exp_id[pkt_seen];
                    if (bidx == 0)      check("R2", out_data, exp_beat(id, 0), "port beat");
                    else if (bidx == 1) check("R3", out_data, exp_beat(id, 1), "length beat");
                    else if (bidx < 5)  check("R4", out_data, exp_beat(id, bidx), "id/timestamp beat");
                    else                check("R5", out_data, exp_beat(id, bidx), "counter beat");
                    check("R9", {31'b0, out_sop}, {31'b0, bidx == 0}, "sop position");
                    check("R5", {31'b0, out_eop}, {31'b0, bidx == 8}, "eop position");
                    if (bidx == 8) begin
                        bidx = 0;
                        pkt_seen++;
                    end else begin
                        bidx++;
                    end
                end
            end
        end
    end

    initial begin
        int nid;
        nid = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", {29'b0, out_valid, fifo_full, overflow}, 32'd0, "state in reset");
        @(posedge clk); #1;
        rst = 1'b0;
        running = 1;
        @(negedge clk);
        check("R1", {29'b0, out_valid, fifo_full, overflow}, 32'd0, "state after reset");
        repeat (8) begin
            @(negedge clk);
            check("R6", {31'b0, out_valid}, 32'd0, "idle while empty");
        end

        for (int m = 0; m < 3; m++) begin
            mode = m;
            for (int n = 1; n <= 5; n++) begin
                @(posedge clk); #1;
                for (int j = 0; j < n; j++) begin
                    push_rec(nid, 1);
                    nid++;
                end
                while (pkt_seen < exp_wr) @(negedge clk);
                repeat (3) @(negedge clk);
                check("R6", {31'b0, out_valid}, 32'd0, "idle after drain");
                check("R6", 32'(pkt_seen), 32'(exp_wr), "packet count");
            end
        end

        mode = 3;
        @(posedge clk); #1;
        for (int j = 0; j < DEPTH; j++) begin
            push_rec(nid, 1);
            nid++;
        end
        @(negedge clk);
        check("R8", {30'b0, fifo_full, overflow}, 32'd2, "full without overflow");
        @(posedge clk); #1;
        push_rec(nid, 0);
        nid++;
        @(negedge clk);
        check("R8", {30'b0, fifo_full, overflow}, 32'd3, "dropped push sets overflow");
        mode = 0;
        while (pkt_seen < exp_wr) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R8", 32'(pkt_seen), 32'(exp_wr), "only queued records sent");
        check("R8", {30'b0, fifo_full, overflow}, 32'd1, "overflow sticky after drain");
        check("R6", {31'b0, out_valid}, 32'd0, "idle after overflow drain");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule